// File: doc/BRIEF.md
# Multi-Channel Interval Timer Bank

This block holds a set of independent 32-bit interval timers, two by default, that share one word-addressed register bus and one level interrupt line. Each channel has a control/status word, a load word and a read-only counter. Software writes a load value, then writes the control word with the run bit set. The channel counts toward its terminal value on each cycle where its count-enable tick is high.

The terminal value is zero when the channel counts down and all-ones when it counts up. When the channel takes a tick while sitting at the terminal value, it sets a sticky event flag. It then either reloads from the load word and keeps running, or stops. The shared interrupt output is high while any channel has both its event flag and its interrupt-enable bit set. Software clears a flag by writing a one to it.

The bus is a single-cycle write strobe with a combinational read port. A register is addressed as `channel*4 + slot`: slot 0 is control, slot 1 is load, slot 2 is the counter and slot 3 is unused.

Top module: `tmr_bank`

## Requirements
- R1: Control word bits are: bit1 direction (1 = down), bit4 auto-reload, bit5 hold-at-load, bit6 interrupt enable, bit7 run, bit8 event flag. The other bits are stored and read back with no effect. Word address `ch*4+0` is control, `+1` is load and `+2` is the counter.
- R2: A control write with bit7 set copies the load word into the counter and starts the channel. A control write with bit7 clear stops the channel and leaves the counter value unchanged.
- R3: A running channel steps the counter by one on each tick, downward when bit1 is 1 and upward when bit1 is 0.
- R4: A tick taken while the counter is at the terminal value (zero when counting down, all-ones when counting up) is an expiry and sets the event flag.
- R5: On expiry with auto-reload set, the counter is reloaded from the load word and the channel keeps running. Without auto-reload the channel stops and the counter stays at the terminal value.
- R6: Writing 1 to control bit8 clears the event flag. Writing 0 to bit8 leaves the flag unchanged. A bus write can never set the flag.
- R7: If a clearing write and an expiry happen in the same cycle, the flag ends up set.
- R8: While bit5 is 1, the counter follows the load word one cycle behind and does not count.
- R9: The counter moves only in cycles where the channel's tick input is 1 and its run bit is 1.
- R10: The interrupt output is the OR over all channels of (event flag AND bit6).
- R11: Synchronous reset clears every register, stops every channel and drives the interrupt output low.
- R12: Reads of slot 3, or of a channel index at or above NUM_CH, return zero. Writes to those addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | AW (6) | Word address: channel index in the upper bits, slot in bits [1:0] |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Combinational read data for bus_addr |
| tick | input | NUM_CH (2) | Count-enable tick, one per channel |
| irq | output | 1 | Shared level interrupt |

## Verification
The hardest case to reach is a flag-clearing control write that lands on the same clock edge as an expiry. To get there, the bench parks an up-counting channel at all-ones. It then raises that channel's tick in the same cycle it drives the clearing write, and checks that the flag and the interrupt both survive. Hold-at-load is also hard to observe. The bench changes the load word while hold is active and reads back the counter to see it follow the new value without counting.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int B_MODE  = 0;
    localparam int B_DOWN  = 1;
    localparam int B_GEN   = 2;
    localparam int B_CAPT  = 3;
    localparam int B_AREL  = 4;
    localparam int B_HOLD  = 5;
    localparam int B_IEN   = 6;
    localparam int B_RUN   = 7;
    localparam int B_FLAG  = 8;

    typedef enum logic [1:0] {
        SLOT_CTRL  = 2'd0,
        SLOT_LOAD  = 2'd1,
        SLOT_COUNT = 2'd2,
        SLOT_NONE  = 2'd3
    } slot_e;

    typedef struct packed {
        logic down;
        logic arel;
        logic hold;
        logic ien;
        logic run;
    } ctrl_view_t;

    function automatic ctrl_view_t view_ctrl(input logic [31:0] c);
        ctrl_view_t v;
        v.down = c[B_DOWN];
        v.arel = c[B_AREL];
        v.hold = c[B_HOLD];
        v.ien  = c[B_IEN];
        v.run  = c[B_RUN];
        return v;
    endfunction
endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ctrl_we,
    input  logic          load_we,
    input  logic [DW-1:0] wdata,
    input  logic          tick,
    output logic [DW-1:0] ctrl_rd,
    output logic [DW-1:0] load_rd,
    output logic [DW-1:0] cnt_rd,
    output logic          irq_req
);
    logic [DW-1:0] ctrl_q, load_q, cnt_q;
    logic          flag_q, act_q;
    ctrl_view_t    cv;
    logic [DW-1:0] term;
    logic          step, expire;

    always_comb begin
        cv     = view_ctrl(32'(ctrl_q));
        term   = cv.down ? '0 : '1;
        step   = act_q && cv.run && tick && !cv.hold;
        expire = step && (cnt_q == term);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            load_q <= '0;
            cnt_q  <= '0;
            flag_q <= 1'b0;
            act_q  <= 1'b0;
        end else begin
            if (ctrl_we) begin
                ctrl_q         <= wdata;
                ctrl_q[B_FLAG] <= 1'b0;
            end
            if (load_we)
                load_q <= wdata;

            if (expire)
                flag_q <= 1'b1;
            else if (ctrl_we && wdata[B_FLAG])
                flag_q <= 1'b0;

            if (ctrl_we) begin
                if (wdata[B_RUN]) begin
                    cnt_q <= load_q;
                    act_q <= 1'b1;
                end else begin
                    act_q <= 1'b0;
                end
            end else if (cv.hold) begin
                cnt_q <= load_q;
            end else if (expire) begin
                if (cv.arel) cnt_q <= load_q;
                else         act_q <= 1'b0;
            end else if (step) begin
                cnt_q <= cv.down ? cnt_q - 1'b1 : cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        ctrl_rd         = ctrl_q;
        ctrl_rd[B_FLAG] = flag_q;
        load_rd         = load_q;
        cnt_rd          = cnt_q;
        irq_req         = flag_q && cv.ien;
    end

    AST_EXPIRY_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        expire |=> flag_q); // R4
    AST_WRITE_NEVER_SETS: assert property (@(posedge clk) disable iff (rst)
        (!expire && !flag_q) |=> !flag_q); // R6
    AST_IDLE_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
        (!tick && !ctrl_we && !cv.hold) |=> $stable(cnt_q)); // R9
    AST_HOLD_TRACKS: assert property (@(posedge clk) disable iff (rst)
        (cv.hold && !ctrl_we) |=> (cnt_q == $past(load_q))); // R8
    AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (rst)
        (expire && !cv.arel && !ctrl_we) |=> !act_q); // R5
endmodule

// File: rtl/tmr_rd_mux.sv
module tmr_rd_mux
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int DW     = 32,
    parameter int AW     = 6
) (
    input  logic [AW-1:0]              addr,
    input  logic [NUM_CH-1:0][DW-1:0]  ctrl_v,
    input  logic [NUM_CH-1:0][DW-1:0]  load_v,
    input  logic [NUM_CH-1:0][DW-1:0]  cnt_v,
    output logic [DW-1:0]              rdata
);
    localparam int CHW = AW - 2;
    logic [CHW-1:0] ch;
    slot_e          slot;

    always_comb begin
        ch    = addr[AW-1:2];
        slot  = slot_e'(addr[1:0]);
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch == CHW'(i)) begin
                case (slot)
                    SLOT_CTRL:  rdata = ctrl_v[i];
                    SLOT_LOAD:  rdata = load_v[i];
                    SLOT_COUNT: rdata = cnt_v[i];
                    default:    rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int DW     = 32,
    parameter int AW     = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NUM_CH-1:0] tick,
    output logic              irq
);
    localparam int CHW = AW - 2;

    logic [NUM_CH-1:0][DW-1:0] ctrl_v, load_v, cnt_v;
    logic [NUM_CH-1:0]         req_v;
    logic [CHW-1:0]            wr_ch;
    slot_e                     wr_slot;

    assign wr_ch   = bus_addr[AW-1:2];
    assign wr_slot = slot_e'(bus_addr[1:0]);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic hit;
        assign hit = bus_wr && (wr_ch == CHW'(g));
        tmr_channel #(.DW(DW)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .ctrl_we (hit && wr_slot == SLOT_CTRL),
            .load_we (hit && wr_slot == SLOT_LOAD),
            .wdata   (bus_wdata),
            .tick    (tick[g]),
            .ctrl_rd (ctrl_v[g]),
            .load_rd (load_v[g]),
            .cnt_rd  (cnt_v[g]),
            .irq_req (req_v[g])
        );
    end

    tmr_rd_mux #(.NUM_CH(NUM_CH), .DW(DW), .AW(AW)) u_mux (
        .addr   (bus_addr),
        .ctrl_v (ctrl_v),
        .load_v (load_v),
        .cnt_v  (cnt_v),
        .rdata  (bus_rdata)
    );

    assign irq = |req_v;

    AST_IRQ_AFTER_RESET: assert property (@(posedge clk)
        rst |=> !irq); // R11
endmodule

// File: tb/test_tmr_bank.sv
module test_tmr_bank;
    localparam int NUM_CH = 2;
    localparam int DW = 32;
    localparam int AW = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [NUM_CH-1:0] tick = '0;
    logic irq;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    tmr_bank #(.NUM_CH(NUM_CH), .DW(DW), .AW(AW)) i_tmr_bank (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick), .irq(irq)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic wr_tick(input int a, input logic [DW-1:0] d, input int ch);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d; tick[ch] = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0; tick[ch] = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int a, input logic [DW-1:0] exp);
        @(negedge clk);
        bus_addr = AW'(a);
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic pulse(input int ch, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick[ch] = 1'b1;
            @(posedge clk); #1; tick[ch] = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        #1;
    endtask

    task automatic irq_chk(input string req, input logic exp);
        @(negedge clk);
        check(req, {31'b0, irq}, {31'b0, exp});
    endtask

    task automatic t_reset;
        rd_chk("R11 ctrl0", 0, 0);
        rd_chk("R11 load0", 1, 0);
        rd_chk("R11 cnt1", 6, 0);
        irq_chk("R11 irq", 1'b0);
    endtask

    task automatic t_down_oneshot;
        wr(1, 3);
        wr(0, 32'h82);
        rd_chk("R2 start count", 2, 3);
        pulse(0, 2);
        rd_chk("R3 down step", 2, 1);
        pulse(0, 2);
        rd_chk("R4 flag set", 0, 32'h182);
        irq_chk("R10 masked", 1'b0);
        pulse(0, 3);
        rd_chk("R5 stopped at zero", 2, 0);
    endtask

    task automatic t_up_reload;
        wr(5, 32'hFFFF_FFFE);
        wr(4, 32'hD0);
        pulse(1, 1);
        rd_chk("R3 up step", 6, 32'hFFFF_FFFF);
        pulse(1, 1);
        rd_chk("R5 reload", 6, 32'hFFFF_FFFE);
        irq_chk("R10 irq high", 1'b1);
        pulse(1, 1);
        rd_chk("R5 keeps running", 6, 32'hFFFF_FFFF);
    endtask

    task automatic t_clear;
        wr(4, 32'hD0);
        rd_chk("R6 write 0 keeps flag", 4, 32'h1D0);
        wr(4, 32'h1D0);
        rd_chk("R6 write 1 clears", 4, 32'hD0);
        irq_chk("R10 irq low", 1'b0);
        pulse(1, 1);
        wr_tick(4, 32'h1D0, 1);
        rd_chk("R7 collision keeps flag", 4, 32'h1D0);
        irq_chk("R7 irq stays", 1'b1);
        wr(4, 32'h1D0);
        wr(0, 32'h100);
        rd_chk("R6 clear ch0", 0, 0);
        wr(0, 32'h100);
        rd_chk("R6 no sw set", 0, 0);
        irq_chk("R10 all clear", 1'b0);
    endtask

    task automatic t_hold;
        wr(1, 10);
        wr(0, 32'hA2);
        pulse(0, 3);
        rd_chk("R8 held", 2, 10);
        wr(1, 20);
        idle(1);
        rd_chk("R8 follows load", 2, 20);
        wr(0, 32'h82);
        pulse(0, 1);
        rd_chk("R2 restart from load", 2, 19);
    endtask

    task automatic t_gating;
        idle(5);
        rd_chk("R9 no tick", 2, 19);
        pulse(1, 2);
        rd_chk("R9 other tick", 2, 19);
        wr(0, 32'h02);
        pulse(0, 2);
        rd_chk("R2 stop keeps count", 2, 19);
        rd_chk("R1 ctrl readback", 0, 32'h02);
    endtask

    task automatic t_unmapped;
        rd_chk("R12 slot3", 3, 0);
        rd_chk("R12 ch2 ctrl", 8, 0);
        wr(9, 32'h55);
        wr(11, 32'h66);
        rd_chk("R12 ch2 load", 9, 0);
        rd_chk("R12 ch0 load", 1, 20);
        rd_chk("R12 ch1 load", 5, 32'hFFFF_FFFE);
    endtask

    initial begin
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_down_oneshot();
        t_up_reload();
        t_clear();
        t_hold();
        t_gating();
        t_unmapped();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule